// File: doc/BRIEF.md
# SPI Target Buffered Event Controller

This block is the serial front end of a host-command link. An external SPI host selects the block with an active-low chip select and clocks bytes in on MOSI. The block stores them in a 128-byte input buffer and returns bytes from a 128-byte output buffer on MISO. It uses SPI mode 0 and sends the most significant bit first. The chip select, serial clock and MOSI lines are sampled into the system clock domain. Chip select then passes through a glitch filter, so a short low pulse is never taken as a transaction.

Local software sees the block through a single-cycle byte register port. Through it, software loads the output buffer, reads back the received bytes and the fill pointers, and sets up two input-level thresholds. Software also reads and clears event flags. There are two level events: a fixed half-buffer level, and a programmable early level used to detect a command header. Each chip-select edge has its own event. The deassert event fires even when no serial clock toggled during the select window. The older end-of-receive flag needs at least one clock edge. One interrupt line reports every enabled flag.

The register port has no back-pressure. It is always ready, a write takes effect at the clock edge where `reg_wr` is high, and read data is valid combinationally in the same cycle. The serial side has no flow control. The host sets the pace, and the block accepts every byte.

Top module: `spi_hostlink_target`

## Requirements
- R1: After reset, the block is in the following state. Event registers 0x04 and 0x0F read 0. Status register 0x08 bit 0 (busy) reads 0. The input pointer at 0x0A and the output pointer at 0x0B read 0. `irq` is low.
- R2: While chip select is asserted, each group of 8 bits sampled on SCLK rising edges forms one byte, MSB first. Byte n of a transaction is stored at input buffer index n mod 128. Software reads input buffer index i at address 0xA0+i. The input pointer at 0x0A then reads the byte count mod 128.
- R3: Software writes output buffer index i at address 0x20+i. Byte n of a transaction is taken from output index n mod 128 and driven on MISO MSB first. The first bit is valid before the first SCLK rising edge, and each later bit changes after an SCLK falling edge.
- R4: The input pointer wraps from 127 to 0. Both pointers return to 0 on every accepted chip-select assertion.
- R5: Event register 0x04 bit 0 sets when a stored byte brings the input pointer to 64. This does not happen while configuration register 0x0C bit 7 is 1.
- R6: Event register 0x0F bit 0 sets when a stored byte brings the input pointer to the value in 0x0E bits [5:0]. It does not set while 0x0E bit 7 is 1, and a threshold of 0 never fires.
- R7: An accepted chip-select assertion sets 0x0F bit 2, and the following deassertion sets 0x0F bit 1, even when no clock edge occurred. 0x04 bit 1 (end of receive) sets on deassertion only when at least one SCLK rising edge was seen while selected.
- R8: Writing 1 to a bit of 0x04 or 0x0F clears that flag. Writing 0 leaves it unchanged.
- R9: `irq` is high exactly when some flag of 0x04 is 1 with the same bit of enable register 0x05 set, or some flag of 0x0F is 1 with the same bit of 0x10 set.
- R10: A chip-select low pulse shorter than the filter length (4 system clocks) is ignored. It sets no event and does not reset the pointers.
- R11: Status register 0x08 bit 0 reads 1 while an accepted chip-select assertion is in progress, and 0 otherwise.
- R12: SCLK and MOSI activity while chip select is deasserted stores no byte and leaves the input pointer and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock from the host (mode 0) |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq | output | 1 | Interrupt, OR of enabled flags |

## Verification
The assertions check several rules on every cycle:
- Each accepted assertion clears the pointers and raises the falling-edge flag in the next cycle.
- Each deassertion raises the rising-edge flag.
- The input pointer wraps after index 127.
- No byte is stored while unselected.
- The half-level flag follows the 64th byte.
- The interrupt is never high without a pending flag.

Some behaviour only the bench scenarios can show:
- the serial content in both directions;
- the exact programmable threshold crossing;
- glitch rejection;
- the write-one-to-clear rules;
- the masking of the interrupt for random enable patterns.

// File: rtl/hl_pkg.sv
package hl_pkg;
  // Register map (byte addresses on the register port)
  localparam int A_EVT1 = 'h004;  // [0] half level, [1] end of receive
  localparam int A_EN1  = 'h005;
  localparam int A_STAT = 'h008;  // [0] busy
  localparam int A_IPTR = 'h00A;
  localparam int A_OPTR = 'h00B;
  localparam int A_CFGA = 'h00C;  // [7] half-level event off
  localparam int A_CFGB = 'h00D;  // reserved, reads 0
  localparam int A_CFGC = 'h00E;  // [7] early-level off, [5:0] threshold
  localparam int A_EVT2 = 'h00F;  // [0] early level, [1] cs rise, [2] cs fall
  localparam int A_EN2  = 'h010;
  localparam int A_OBUF = 'h020;
  localparam int A_IBUF = 'h0A0;

  typedef struct packed {
    logic busy;
    logic cs_fall;
    logic cs_rise;
    logic sck_rise;
    logic sck_fall;
    logic mosi;
  } pin_ev_t;
endpackage

// File: rtl/hl_pin_sync.sv
module hl_pin_sync
  import hl_pkg::*;
#(
  parameter int FILT_CYC = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_n,
  input  logic    sck,
  input  logic    mosi,
  output pin_ev_t ev
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0] cs_s, sck_s, mosi_s;
  logic       sck_d, cs_filt, cs_filt_d;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s      <= 2'b11;
      sck_s     <= 2'b00;
      mosi_s    <= 2'b00;
      sck_d     <= 1'b0;
      cs_filt   <= 1'b1;
      cs_filt_d <= 1'b1;
      cnt       <= '0;
    end else begin
      cs_s      <= {cs_s[0], cs_n};
      sck_s     <= {sck_s[0], sck};
      mosi_s    <= {mosi_s[0], mosi};
      sck_d     <= sck_s[1];
      cs_filt_d <= cs_filt;
      // filtered select follows only after FILT_CYC steady cycles
      if (cs_s[1] == cs_filt) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_CYC - 1)) begin
        cnt     <= '0;
        cs_filt <= cs_s[1];
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_comb begin
    ev.busy     = ~cs_filt;
    ev.cs_fall  = cs_filt_d & ~cs_filt;
    ev.cs_rise  = ~cs_filt_d & cs_filt;
    ev.sck_rise = sck_s[1] & ~sck_d;
    ev.sck_fall = ~sck_s[1] & sck_d;
    ev.mosi     = mosi_s[1];
  end
endmodule

// File: rtl/hl_shift.sv
module hl_shift
  import hl_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pin_ev_t          ev,
  input  logic [7:0]       obuf_data,
  output logic [PTR_W-1:0] obuf_idx,
  output logic             miso,
  output logic             byte_wr,
  output logic [7:0]       byte_data,
  output logic [PTR_W-1:0] in_ptr,
  output logic [PTR_W-1:0] out_ptr,
  output logic             clk_seen
);
  logic [2:0] bitcnt;
  logic [7:0] sh_in, sh_out;

  assign obuf_idx  = ev.cs_fall ? '0 : out_ptr + PTR_W'(1);
  assign byte_wr   = ev.busy & ~ev.cs_fall & ev.sck_rise & (bitcnt == 3'd7);
  assign byte_data = {sh_in[6:0], ev.mosi};
  assign miso      = ev.busy & sh_out[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt   <= '0;
      sh_in    <= '0;
      sh_out   <= '0;
      in_ptr   <= '0;
      out_ptr  <= '0;
      clk_seen <= 1'b0;
    end else if (ev.cs_fall) begin
      bitcnt   <= '0;
      sh_in    <= '0;
      sh_out   <= obuf_data;
      in_ptr   <= '0;
      out_ptr  <= '0;
      clk_seen <= 1'b0;
    end else if (ev.busy) begin
      if (ev.sck_rise) begin
        sh_in    <= byte_data;
        bitcnt   <= bitcnt + 3'd1;
        clk_seen <= 1'b1;
        if (bitcnt == 3'd7) in_ptr <= in_ptr + PTR_W'(1);
      end
      if (ev.sck_fall) begin
        if (bitcnt == 3'd0 && clk_seen) begin
          sh_out  <= obuf_data;
          out_ptr <= out_ptr + PTR_W'(1);
        end else begin
          sh_out <= {sh_out[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/hl_events.sv
module hl_events #(
  parameter int DEPTH = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int NFLAG = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_wr,
  input  logic [PTR_W-1:0] in_ptr,
  input  logic             l1_dis,
  input  logic             l2_dis,
  input  logic [5:0]       l2_thr,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             clk_seen,
  input  logic [1:0]       clr1,
  input  logic [2:0]       clr2,
  input  logic [1:0]       en1,
  input  logic [2:0]       en2,
  output logic [1:0]       evt1,
  output logic [2:0]       evt2,
  output logic             irq
);
  logic [PTR_W-1:0] nxt;
  logic [NFLAG-1:0] set_v, clr_v, en_v, flag_q;

  assign nxt = in_ptr + PTR_W'(1);

  always_comb begin
    set_v[0] = byte_wr & ~l1_dis & (nxt == PTR_W'(DEPTH / 2));
    set_v[1] = cs_rise & clk_seen;
    set_v[2] = byte_wr & ~l2_dis & (l2_thr != 6'd0) & (nxt == PTR_W'(l2_thr));
    set_v[3] = cs_rise;
    set_v[4] = cs_fall;
  end

  assign clr_v = {clr2, clr1};
  assign en_v  = {en2, en1};

  // one sticky flag per event, set wins over a same-cycle clear
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[g] <= 1'b0;
      else if (set_v[g])   flag_q[g] <= 1'b1;
      else if (clr_v[g])   flag_q[g] <= 1'b0;
    end
  end

  assign evt1 = flag_q[1:0];
  assign evt2 = flag_q[4:2];
  assign irq  = |(flag_q & en_v);
endmodule

// File: rtl/spi_hostlink_target.sv
module spi_hostlink_target
  import hl_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int FILT_CYC = 4,
  parameter int ADDR_W   = 9,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  pin_ev_t          ev;
  logic [7:0]       obuf [DEPTH];
  logic [7:0]       ibuf [DEPTH];
  logic [PTR_W-1:0] obuf_idx, in_ptr, out_ptr, buf_off;
  logic [7:0]       byte_data;
  logic             byte_wr, clk_seen;
  logic             l1_dis, l2_dis;
  logic [5:0]       l2_thr;
  logic [1:0]       en1, evt1, clr1;
  logic [2:0]       en2, evt2, clr2;
  logic             in_ob, in_ib;
  int               a;

  assign a     = int'(reg_addr);
  assign in_ob = (a >= A_OBUF) && (a < A_OBUF + DEPTH);
  assign in_ib = (a >= A_IBUF) && (a < A_IBUF + DEPTH);
  assign buf_off = in_ob ? PTR_W'(a - A_OBUF) : PTR_W'(a - A_IBUF);

  hl_pin_sync #(.FILT_CYC(FILT_CYC)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck),
    .mosi(spi_mosi), .ev(ev)
  );

  hl_shift #(.DEPTH(DEPTH)) u_shift (
    .clk(clk), .rst_n(rst_n), .ev(ev), .obuf_data(obuf[obuf_idx]),
    .obuf_idx(obuf_idx), .miso(spi_miso), .byte_wr(byte_wr),
    .byte_data(byte_data), .in_ptr(in_ptr), .out_ptr(out_ptr),
    .clk_seen(clk_seen)
  );

  assign clr1 = (reg_wr && a == A_EVT1) ? reg_wdata[1:0] : 2'b00;
  assign clr2 = (reg_wr && a == A_EVT2) ? reg_wdata[2:0] : 3'b000;

  hl_events #(.DEPTH(DEPTH)) u_events (
    .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .in_ptr(in_ptr),
    .l1_dis(l1_dis), .l2_dis(l2_dis), .l2_thr(l2_thr),
    .cs_fall(ev.cs_fall), .cs_rise(ev.cs_rise), .clk_seen(clk_seen),
    .clr1(clr1), .clr2(clr2), .en1(en1), .en2(en2),
    .evt1(evt1), .evt2(evt2), .irq(irq)
  );

  // configuration and enable registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1_dis <= 1'b0;
      l2_dis <= 1'b1;
      l2_thr <= '0;
      en1    <= '0;
      en2    <= '0;
    end else if (reg_wr) begin
      case (a)
        A_CFGA: l1_dis <= reg_wdata[7];
        A_CFGC: begin
          l2_dis <= reg_wdata[7];
          l2_thr <= reg_wdata[5:0];
        end
        A_EN1:  en1 <= reg_wdata[1:0];
        A_EN2:  en2 <= reg_wdata[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (reg_wr && in_ob) obuf[buf_off] <= reg_wdata;
    if (byte_wr)         ibuf[in_ptr]  <= byte_data;
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (in_ob)      reg_rdata = obuf[buf_off];
    else if (in_ib) reg_rdata = ibuf[buf_off];
    else begin
      case (a)
        A_EVT1: reg_rdata = {6'b0, evt1};
        A_EN1:  reg_rdata = {6'b0, en1};
        A_STAT: reg_rdata = {7'b0, ev.busy};
        A_IPTR: reg_rdata = 8'(in_ptr);
        A_OPTR: reg_rdata = 8'(out_ptr);
        A_CFGA: reg_rdata = {l1_dis, 7'b0};
        A_CFGB: reg_rdata = 8'h00;
        A_CFGC: reg_rdata = {l2_dis, 1'b0, l2_thr};
        A_EVT2: reg_rdata = {5'b0, evt2};
        A_EN2:  reg_rdata = {5'b0, en2};
        default: reg_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/hl_chk.sv
module hl_chk #(
  parameter int DEPTH = 128,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             byte_wr,
  input logic [PTR_W-1:0] in_ptr,
  input logic             l1_dis,
  input logic [1:0]       evt1,
  input logic [2:0]       evt2,
  input logic             irq
);
  assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (in_ptr == '0));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && in_ptr == PTR_W'(DEPTH - 1)) |=> (in_ptr == '0));

  assert_fall_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> evt2[2]);

  assert_rise_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> evt2[1]);

  assert_half_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && !l1_dis && in_ptr == PTR_W'(DEPTH / 2 - 1)) |=> evt1[0]);

  assert_idle_no_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !byte_wr);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((evt1 != 2'b00) || (evt2 != 3'b000)));
endmodule

bind spi_hostlink_target hl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(ev.busy), .byte_wr(byte_wr),
  .in_ptr(in_ptr), .l1_dis(l1_dis), .evt1(evt1), .evt2(evt2), .irq(irq)
);

// File: tb/spi_hostlink_target_tb.sv
module spi_hostlink_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int DEPTH = 128;

  logic       clk = 0, rst_n = 0;
  logic       cs_n = 1, sck = 0, mosi = 0;
  logic       miso, wr_en = 0, irq;
  logic [8:0] addr = 0;
  logic [7:0] wdata = 0, rdata;

  int vecs = 0, fails = 0;
  bit done = 0;

  logic [7:0] ob_m [DEPTH];
  logic [7:0] ib_m [DEPTH];
  logic [7:0] mosi_q [256];
  logic [7:0] miso_q [256];

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_hostlink_target u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso), .reg_wr(wr_en), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; addr = 9'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    wr_en = 0; addr = 9'(a);
    #1 d = int'(rdata);
  endtask

  function automatic int exp_irq(int e1, int e2, int n1, int n2);
    return ((e1 & n1) != 0 || (e2 & n2) != 0) ? 1 : 0;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one select window carrying n bytes
  task automatic xfer(input int n);
    int v;
    logic [7:0] got;
    @(negedge clk);
    cs_n = 0;
    idle(10);
    rd('h008, v);
    check_eq("R11 busy during select", v & 1, 1);
    for (int b = 0; b < n; b++) begin
      for (int k = 7; k >= 0; k--) begin
        mosi = mosi_q[b][k];
        idle(HALF);
        sck = 1;
        got[k] = miso;
        idle(HALF);
        sck = 0;
      end
      miso_q[b] = got;
    end
    idle(HALF);
    cs_n = 1;
    idle(12);
    rd('h008, v);
    check_eq("R11 busy after deselect", v & 1, 0);
  endtask

  task automatic run_case(input int n, input int l1d, input int thr,
                          input int l2d, input int n1, input int n2);
    int v, e1, e2;
    for (int i = 0; i < DEPTH; i++) begin
      ob_m[i] = 8'($urandom);
      wr('h020 + i, ob_m[i]);
    end
    wr('h00C, l1d << 7);
    wr('h00E, (l2d << 7) | thr);
    wr('h005, n1);
    wr('h010, n2);
    wr('h004, 'hFF);
    wr('h00F, 'hFF);
    for (int b = 0; b < n; b++) begin
      mosi_q[b] = 8'($urandom);
      ib_m[b % DEPTH] = mosi_q[b];
    end
    xfer(n);
    for (int b = 0; b < n; b++)
      check_eq($sformatf("R3 miso byte %0d", b), miso_q[b], ob_m[b % DEPTH]);
    for (int i = 0; i < (n < DEPTH ? n : DEPTH); i++) begin
      rd('h0A0 + i, v);
      check_eq($sformatf("R2 ibuf %0d", i), v, ib_m[i]);
    end
    rd('h00A, v);
    check_eq("R4 in pointer wrap", v, n % DEPTH);
    e1 = ((l1d == 0 && n >= 64) ? 1 : 0) | ((n > 0) ? 2 : 0);
    e2 = ((l2d == 0 && thr != 0 && n >= thr) ? 1 : 0) | 6;
    rd('h004, v);
    check_eq("R5 R7 evt1", v, e1);
    rd('h00F, v);
    check_eq("R6 R7 evt2", v, e2);
    check_eq("R9 irq", int'(irq), exp_irq(e1, e2, n1, n2));
  endtask

  initial begin
    int v;
    void'($urandom(32'h5EED_1234));
    idle(5);
    rst_n = 1;
    idle(2);
    // R1 reset state
    rd('h004, v); check_eq("R1 evt1", v, 0);
    rd('h00F, v); check_eq("R1 evt2", v, 0);
    rd('h008, v); check_eq("R1 busy", v, 0);
    rd('h00A, v); check_eq("R1 in ptr", v, 0);
    rd('h00B, v); check_eq("R1 out ptr", v, 0);
    check_eq("R1 irq", int'(irq), 0);

    // R7 select with no clock
    wr('h010, 'h04);
    @(negedge clk); cs_n = 0; idle(10); cs_n = 1; idle(12);
    rd('h00F, v); check_eq("R7 edge flags no clock", v, 'h6);
    rd('h004, v); check_eq("R7 no end-of-receive", v, 0);
    check_eq("R9 irq on fall flag", int'(irq), 1);
    // R8 write-one-to-clear
    wr('h00F, 'h02); rd('h00F, v); check_eq("R8 clear bit1 only", v, 'h4);
    wr('h00F, 'h00); rd('h00F, v); check_eq("R8 zero write keeps", v, 'h4);
    check_eq("R9 irq held", int'(irq), 1);
    wr('h00F, 'h04); rd('h00F, v); check_eq("R8 clear bit2", v, 0);
    check_eq("R9 irq released", int'(irq), 0);

    // R6 threshold exactly at / below
    run_case(7, 0, 8, 0, 0, 1);
    run_case(8, 0, 8, 0, 0, 1);
    // R5 at 63 and 64, and disabled
    run_case(63, 0, 9, 1, 1, 0);
    run_case(64, 0, 9, 1, 1, 0);
    run_case(64, 1, 9, 0, 3, 7);

    // R10 glitch: short low pulse
    wr('h004, 'hFF); wr('h00F, 'hFF);
    @(negedge clk); cs_n = 0; idle(2); cs_n = 1; idle(12);
    rd('h00F, v); check_eq("R10 glitch no events", v, 0);
    rd('h00A, v); check_eq("R10 glitch ptr kept", v, 64);

    // R12 clocks while deselected
    for (int k = 0; k < 16; k++) begin
      mosi = k[0]; idle(HALF); sck = 1; idle(HALF); sck = 0;
    end
    idle(8);
    rd('h00A, v); check_eq("R12 ptr unchanged", v, 64);
    rd('h004, v); check_eq("R12 evt1 unchanged", v, 0);
    rd('h00F, v); check_eq("R12 evt2 unchanged", v, 0);

    // constrained random
    for (int t = 0; t < 14; t++) begin
      int n;
      n = (t % 7 == 6) ? 128 + int'($urandom % 10) : 1 + int'($urandom % 70);
      run_case(n, ($urandom % 4 == 0) ? 1 : 0, 1 + int'($urandom % 63),
               ($urandom % 4 == 0) ? 1 : 0, int'($urandom % 4),
               int'($urandom % 8));
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      vecs++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule